// File: doc/BRIEF.md
# Circular Branch Trace Buffer

This block is a small debug recorder that sits beside an instruction fetch unit. Each cycle the fetch unit presents a valid strobe, a flag marking the fetch as a jump away from straight-line flow, and the 32-bit fetch address. When both the strobe and the flag are high, the block stores the address in a bank of eight registers. It fills the bank in round-robin order, so the bank always holds the most recent discontinuities in program flow.

A 3-bit pointer names the entry written last. Debug software reads the entries and the pointer through a simple registered read port. From the pointer and the eight entries, software can rebuild the recent path the program took. The port is read-only. Write cycles on the bus leave all stored state unchanged. Reset empties the bank.

Top module: `brtrace_buf`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`), all eight entries and the pointer read as zero, `rd_data` is zero and `rd_vld` is low.
- R2: A cycle is a capture only when `fetch_vld` and `fetch_nonseq` are both high. A cycle with either input low changes neither the entries nor the pointer.
- R3: The first capture after reset writes entry 0 and leaves the pointer at 0.
- R4: Every later capture first advances the pointer by one, modulo 8, and then writes the entry the pointer now names. After entry 7 the next capture goes to entry 0.
- R5: The stored value is the `fetch_addr` presented in the capture cycle.
- R6: A read cycle has `bus_sel` high and `bus_we` low. It loads `rd_data` on the next clock edge and raises `rd_vld` for one cycle. Address decoding: 0 to 7 select an entry. Address 8 selects the pointer, placed in bits 2:0 with zeros above. Addresses 9 to 15 return zero.
- R7: A read and a capture in the same cycle return the value held before the capture.
- R8: A bus write cycle (`bus_sel` and `bus_we` high) changes no entry and does not change the pointer. `rd_vld` is low on the following cycle and `rd_data` is unchanged.
- R9: `rd_data` keeps its value in every cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 1 | Fetch strobe |
| fetch_nonseq | input | 1 | Fetch is non-sequential |
| fetch_addr | input | 32 | Address of the fetched instruction |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write (has no effect) |
| bus_addr | input | 4 | Entry index 0-7, pointer at 8 |
| rd_data | output | 32 | Registered read data |
| rd_vld | output | 1 | `rd_data` was loaded by the previous cycle's read |

## Verification
A pointer that advances wrongly or misses a step shows up at address 8 on the first read after the faulty capture. A stuck or stale empty flag makes the first capture after reset land in entry 1, so a read of entry 0 returns zero instead of the captured address. A wrong write index puts an address into an entry other than the expected one, which the sweep of all eight entries exposes within one pass. A wrong read path or a read taken after the edge shows up as the post-capture value in the same-cycle test, one cycle after the read.

// File: rtl/brt_pkg.sv
// Package: shared decode types for the branch trace buffer.
// Assumes the entry count is a power of two, so the entry index is the low
// bits of the bus address and the pointer sits at the first address above.
package brt_pkg;

    typedef enum logic [1:0] {
        ACC_ENTRY = 2'd0,
        ACC_PTR   = 2'd1,
        ACC_NONE  = 2'd2
    } acc_kind_e;

    // Classify a bus address against an entry count.
    function automatic acc_kind_e classify(input int unsigned addr, input int unsigned depth);
        if (addr < depth)
            return ACC_ENTRY;
        else if (addr == depth)
            return ACC_PTR;
        else
            return ACC_NONE;
    endfunction

endpackage

// File: rtl/brt_ptr_ctrl.sv
// Pointer control: holds the empty flag and the last-written index.
// It produces the write strobe and the write index for the entry bank.
// Assumes at most one capture per cycle.
module brt_ptr_ctrl #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             empty_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o
);
    logic [PTR_W-1:0] ptr_q;
    logic             empty_q;
    logic [PTR_W-1:0] next_idx;

    // Pick the target slot: slot 0 when empty, else one past the pointer.
    always_comb begin
        if (empty_q)
            next_idx = '0;
        else
            next_idx = ptr_q + 1'b1;
    end

    // Update the pointer and clear the empty flag on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            empty_q <= 1'b1;
        end else if (cap_i) begin
            ptr_q   <= next_idx;
            empty_q <= 1'b0;
        end
    end

    assign ptr_o    = ptr_q;
    assign empty_o  = empty_q;
    assign wr_en_o  = cap_i;
    assign wr_idx_o = next_idx;
endmodule

// File: rtl/brt_entry_bank.sv
// Entry bank: DEPTH address registers.
// Exactly one register is written when the write strobe is high.
// Assumes wr_idx_i is below DEPTH.
module brt_entry_bank #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [AW-1:0]    wr_data_i,
    output logic [AW-1:0]    ent_o [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AW-1:0] slot_q;

        // Clear on reset; load the address when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en_i && (wr_idx_i == PTR_W'(g)))
                slot_q <= wr_data_i;
        end

        assign ent_o[g] = slot_q;
    end
endmodule

// File: rtl/brt_read_port.sv
// Read port: registered read of an entry or the pointer.
// The sample is taken from state before the clock edge, so a capture in the
// same cycle is not visible. Write cycles are ignored.
module brt_read_port #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int BA_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel_i,
    input  logic             bus_we_i,
    input  logic [BA_W-1:0]  bus_addr_i,
    input  logic [AW-1:0]    ent_i [DEPTH],
    input  logic [PTR_W-1:0] ptr_i,
    output logic [AW-1:0]    rd_data_o,
    output logic             rd_vld_o
);
    import brt_pkg::*;

    logic [AW-1:0] mux_val;
    logic          rd_req;
    acc_kind_e     kind;

    assign rd_req = bus_sel_i && !bus_we_i;
    assign kind   = classify(int'(bus_addr_i), DEPTH);

    // Select the source word for the addressed location.
    always_comb begin
        unique case (kind)
            ACC_ENTRY: mux_val = ent_i[bus_addr_i[PTR_W-1:0]];
            ACC_PTR:   mux_val = {{(AW-PTR_W){1'b0}}, ptr_i};
            default:   mux_val = '0;
        endcase
    end

    // Register read data on a read request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            rd_vld_o  <= 1'b0;
        end else begin
            rd_vld_o <= rd_req;
            if (rd_req)
                rd_data_o <= mux_val;
        end
    end
endmodule

// File: rtl/brtrace_buf.sv
// Top level: branch trace buffer.
// Records the fetch address of every non-sequential fetch into a circular
// bank and exposes the bank and a last-written pointer through a read-only
// registered port. Assumes DEPTH is a power of two.
module brtrace_buf #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int BA_W  = PTR_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_vld,
    input  logic            fetch_nonseq,
    input  logic [AW-1:0]   fetch_addr,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [BA_W-1:0] bus_addr,
    output logic [AW-1:0]   rd_data,
    output logic            rd_vld
);
    logic             cap;
    logic [PTR_W-1:0] ptr_q;
    logic             empty_q;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [AW-1:0]    ent [DEPTH];

    assign cap = fetch_vld && fetch_nonseq;

    brt_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .ptr_o    (ptr_q),
        .empty_o  (empty_q),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx)
    );

    brt_entry_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (fetch_addr),
        .ent_o     (ent)
    );

    brt_read_port #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel_i  (bus_sel),
        .bus_we_i   (bus_we),
        .bus_addr_i (bus_addr),
        .ent_i      (ent),
        .ptr_i      (ptr_q),
        .rd_data_o  (rd_data),
        .rd_vld_o   (rd_vld)
    );
endmodule

// File: rtl/brtrace_buf_chk.sv
// Checker: temporal properties of the trace buffer's pointer and read port.
// It is attached to every brtrace_buf instance by the bind below.
module brtrace_buf_chk #(
    parameter int AW    = 32,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_vld,
    input logic             fetch_nonseq,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [AW-1:0]    rd_data,
    input logic             rd_vld,
    input logic [PTR_W-1:0] ptr_q,
    input logic             empty_q
);
    logic cap;
    assign cap = fetch_vld && fetch_nonseq;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ptr_q == '0) && empty_q && !rd_vld && (rd_data == '0));

    p_no_cap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(ptr_q));

    p_first_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && empty_q) |=> (ptr_q == '0) && !empty_q);

    p_ptr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !empty_q) |=> (ptr_q == $past(ptr_q) + 1'b1));

    p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> rd_vld);

    p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |=> !rd_vld && $stable(rd_data));

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(rd_data));
endmodule

bind brtrace_buf brtrace_buf_chk #(.AW(AW), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_vld    (fetch_vld),
    .fetch_nonseq (fetch_nonseq),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .rd_data      (rd_data),
    .rd_vld       (rd_vld),
    .ptr_q        (ptr_q),
    .empty_q      (empty_q)
);

// File: tb/brtrace_buf_test.sv
// Bench for brtrace_buf: a table-driven pass followed by directed tests.
module brtrace_buf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 1'b0;
    logic        fetch_nonseq = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] rd_data;
    logic        rd_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model_ent [8];
    logic [2:0]  model_ptr;
    bit          model_empty;

    always #4 clk = ~clk;

    brtrace_buf uut (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_nonseq(fetch_nonseq),
        .fetch_addr(fetch_addr), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .rd_data(rd_data), .rd_vld(rd_vld)
    );

    // {vld, nonseq, addr, expected pointer afterwards}
    localparam logic [36:0] VECS [12] = '{
        {1'b1, 1'b1, 32'h1000_0000, 3'd0},
        {1'b1, 1'b0, 32'hDEAD_0001, 3'd0},
        {1'b0, 1'b1, 32'hDEAD_0002, 3'd0},
        {1'b1, 1'b1, 32'h1000_0004, 3'd1},
        {1'b1, 1'b1, 32'h1000_0008, 3'd2},
        {1'b1, 1'b1, 32'h1000_000C, 3'd3},
        {1'b1, 1'b0, 32'hDEAD_0003, 3'd3},
        {1'b1, 1'b1, 32'h1000_0010, 3'd4},
        {1'b1, 1'b1, 32'h1000_0014, 3'd5},
        {1'b1, 1'b1, 32'h1000_0018, 3'd6},
        {1'b1, 1'b1, 32'h1000_001C, 3'd7},
        {1'b1, 1'b1, 32'h1000_0020, 3'd0}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) model_ent[i] = '0;
        model_ptr = '0;
        model_empty = 1'b1;
    endtask

    task automatic model_cap(input logic [31:0] a);
        if (!model_empty) model_ptr = model_ptr + 3'd1;
        model_empty = 1'b0;
        model_ent[model_ptr] = a;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One fetch cycle; the model follows R2.
    task automatic fetch(input logic v, input logic ns, input logic [31:0] a);
        @(negedge clk);
        fetch_vld = v; fetch_nonseq = ns; fetch_addr = a;
        @(posedge clk);
        @(negedge clk);
        fetch_vld = 1'b0; fetch_nonseq = 1'b0;
        if (v && ns) model_cap(a);
    endtask

    // Registered read; samples one cycle after the request.
    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data; v = rd_vld;
    endtask

    initial begin
        logic [31:0] d;
        logic        v;
        logic [31:0] held;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 rd_vld", {31'b0, rd_vld}, 32'h0);
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), d, v);
            chk("R1 reset value", d, 32'h0);
        end

        // R2 R3 R4 R5: table pass, pointer after every step
        for (int k = 0; k < 12; k++) begin
            fetch(VECS[k][36], VECS[k][35], VECS[k][34:3]);
            rd(4'd8, d, v);
            chk("R4 pointer", d, {29'b0, VECS[k][2:0]});
            chk("R6 rd_vld", {31'b0, v}, 32'h1);
        end
        // R5: all entries against the model
        for (int i = 0; i < 8; i++) begin
            rd(4'(i), d, v);
            chk("R5 entry value", d, model_ent[i]);
        end
        chk("R4 wrap entry0", model_ent[0], 32'h1000_0020);
        // R6: out-of-range addresses read zero
        for (int i = 9; i < 16; i++) begin
            rd(4'(i), d, v);
            chk("R6 unmapped", d, 32'h0);
        end

        // R7: read entry 1 in the same cycle as the capture that overwrites it
        @(negedge clk);
        fetch_vld = 1'b1; fetch_nonseq = 1'b1; fetch_addr = 32'hCAFE_0001;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'd1;
        @(posedge clk);
        @(negedge clk);
        fetch_vld = 1'b0; fetch_nonseq = 1'b0; bus_sel = 1'b0;
        chk("R7 old value", rd_data, 32'h1000_0004);
        model_cap(32'hCAFE_0001);
        rd(4'd1, d, v);
        chk("R7 new value", d, 32'hCAFE_0001);

        // R8 R9: write cycles change nothing, rd_data holds
        held = rd_data;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd1;
        @(posedge clk);
        @(negedge clk);
        bus_addr = 4'd8;
        chk("R8 rd_vld low", {31'b0, rd_vld}, 32'h0);
        chk("R8 rd_data held", rd_data, held);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 idle hold", rd_data, held);
        rd(4'd1, d, v);
        chk("R8 entry kept", d, model_ent[1]);
        rd(4'd8, d, v);
        chk("R8 pointer kept", d, {29'b0, model_ptr});

        // R1 R3: reset mid-run, then first capture to entry 0
        do_reset();
        chk("R1 rd_data after reset", rd_data, 32'h0);
        rd(4'd1, d, v);
        chk("R1 entry cleared", d, 32'h0);
        fetch(1'b1, 1'b1, 32'h2000_0040);
        rd(4'd8, d, v);
        chk("R3 pointer stays 0", d, 32'h0);
        rd(4'd0, d, v);
        chk("R3 entry 0", d, 32'h2000_0040);
        fetch(1'b1, 1'b1, 32'h2000_0080);
        rd(4'd8, d, v);
        chk("R4 second capture", d, 32'h1);
        rd(4'd1, d, v);
        chk("R5 entry 1", d, model_ent[1]);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule